// File: doc/BRIEF.md
# Bus Intercycle Idle Inserter

This block sits in front of an external memory bus sequencer. It takes the master's requests and decides how many dead cycles must separate the next bus cycle from the one before it. Each request is presented on a valid/ready handshake and carries a physical area number and a read/write flag. The block compares each request with the last access it accepted. When the area changes, or when a read is followed by a write in the same area, it holds `req_ready` low for a programmed number of idle cycles and raises `idle_active` during those cycles. When the gap is over, it lets the request through. The accepting handshake is the bus-cycle start strobe, `bus_start`.

The idle counts live in an 8-bit control register. Areas 3, 2 and 0 each own a 2-bit field; the other areas have none. The register is written with `cfg_we`/`cfg_wdata` and can be read back at any time on `cfg_rdata`.

Back-pressure rules on the request port:
- Once the master raises `req_valid`, it must keep `req_valid`, `req_area` and `req_write` stable until the cycle in which `req_ready` is high.
- The request is transferred in the cycle where `req_valid && req_ready`.
- `req_ready` is low during every idle cycle.
- A request that needs no gap is accepted in the cycle it is first presented.

Top module: `bus_idle_inserter`

## Requirements
- R1: After reset, `cfg_rdata` reads 0xF3 and `idle_active` is low. The first request after reset is accepted with no idle cycles, that is `req_ready` is high in the cycle it is first presented.
- R2: A register write stores `cfg_wdata` bits 7:6 (area 3 field), 5:4 (area 2 field) and 1:0 (area 0 field), visible on `cfg_rdata` from the next cycle. Bits 3:2 always read 0, whatever is written to them.
- R3: A field value decodes to an idle count as follows: 0 gives 1 idle, 1 gives 1 idle, 2 gives 2 idles and 3 gives 3 idles.
- R4: When the area of a request differs from the area of the previously accepted access, the idle count is taken from the field of the previous area.
- R5: A write that follows a read in the same area inserts the idle count of that area's field.
- R6: Within the same area, a read after a write, a read after a read and a write after a write insert no idle cycles.
- R7: When the previous area is 1, 4, 5, 6 or 7, no idle cycles are inserted, even if the area changes.
- R8: For an idle count N, `idle_active` is high and `req_ready` is low for exactly N consecutive cycles. These cycles begin in the cycle the request is first presented. `bus_start` fires in the cycle after the last idle.
- R9: A register write made during a countdown does not change that countdown. The new value applies from the next transition that is evaluated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control register write enable |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register read data |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted; low during idle cycles |
| req_area | input | 3 | Physical area of the request |
| req_write | input | 1 | Request direction, 1 = write |
| bus_start | output | 1 | Bus-cycle start strobe (request handshake) |
| idle_active | output | 1 | High during an inserted idle cycle |

## Verification
The checker watches several rules on every cycle:
- `req_ready` is never high during an idle cycle.
- No idle run is longer than three cycles.
- The end of an idle run with a pending request always starts a bus cycle.
- The reserved bits read zero, and written data appears on the next cycle.
- The first request after reset is never held.

Only the bench can show that the length of each gap is right for a given pair of accesses and field values. It sweeps every pair of area and direction under four register settings, which covers every code in every field. It also checks that a register write in the middle of a countdown leaves that countdown unchanged and takes effect on the next transition.

// File: rtl/bii_pkg.sv
package bii_pkg;
  localparam int AREA_W    = 3;
  localparam int NUM_AREAS = 1 << AREA_W;
  localparam int CODE_W    = 2;
  localparam int CNT_W     = 2;
  localparam int REG_W     = 8;

  typedef logic [AREA_W-1:0] area_t;
  typedef logic [CODE_W-1:0] code_t;
  typedef logic [CNT_W-1:0]  cnt_t;

  // last accepted access
  typedef struct packed {
    logic  seen;
    area_t area;
    logic  write;
  } hist_t;

  // field value to idle count: codes below 2 both give one idle
  function automatic cnt_t code_to_idles(code_t c);
    if (c < code_t'(2)) return cnt_t'(1);
    return cnt_t'(c);
  endfunction
endpackage

// File: rtl/bii_cfg_regs.sv
module bii_cfg_regs
  import bii_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            we,
  input  logic [REG_W-1:0]                wdata,
  output logic [REG_W-1:0]                rdata,
  output logic [NUM_AREAS-1:0][CODE_W-1:0] area_code,
  output logic [NUM_AREAS-1:0]            area_has
);
  code_t fld_a0, fld_a2, fld_a3;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fld_a0 <= '1;
      fld_a2 <= '1;
      fld_a3 <= '1;
    end else if (we) begin
      fld_a3 <= wdata[7:6];
      fld_a2 <= wdata[5:4];
      fld_a0 <= wdata[1:0];
    end
  end

  assign rdata = {fld_a3, fld_a2, 2'b00, fld_a0};

  for (genvar a = 0; a < NUM_AREAS; a++) begin : g_area
    if (a == 0) begin : g_f0
      assign area_code[a] = fld_a0;
      assign area_has[a]  = 1'b1;
    end else if (a == 2) begin : g_f2
      assign area_code[a] = fld_a2;
      assign area_has[a]  = 1'b1;
    end else if (a == 3) begin : g_f3
      assign area_code[a] = fld_a3;
      assign area_has[a]  = 1'b1;
    end else begin : g_none
      assign area_code[a] = '0;
      assign area_has[a]  = 1'b0;
    end
  end
endmodule

// File: rtl/bii_gap_calc.sv
module bii_gap_calc
  import bii_pkg::*;
(
  input  logic [NUM_AREAS-1:0][CODE_W-1:0] area_code,
  input  logic [NUM_AREAS-1:0]            area_has,
  input  hist_t                           prev,
  input  area_t                           nxt_area,
  input  logic                            nxt_write,
  output cnt_t                            need
);
  logic  switch_area;
  logic  rd_to_wr;
  cnt_t  prev_idles;

  assign switch_area = (prev.area != nxt_area);
  assign rd_to_wr    = !prev.write && nxt_write;
  assign prev_idles  = area_has[prev.area] ? code_to_idles(area_code[prev.area]) : '0;

  always_comb begin
    need = '0;
    if (prev.seen && (switch_area || rd_to_wr)) need = prev_idles;
  end
endmodule

// File: rtl/bii_gap_timer.sv
module bii_gap_timer
  import bii_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  cnt_t need,
  output logic req_ready,
  output logic idle_active,
  output logic fire
);
  cnt_t remain;
  logic waived;
  logic start_gap;

  assign start_gap   = req_valid && !waived && (remain == '0) && (need != '0);
  assign idle_active = (remain != '0) || start_gap;
  assign req_ready   = (remain == '0) && (waived || (need == '0));
  assign fire        = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain <= '0;
      waived <= 1'b0;
    end else begin
      if (remain != '0) remain <= remain - cnt_t'(1);
      else if (start_gap) begin
        remain <= need - cnt_t'(1);
        waived <= 1'b1;
      end
      if (fire) waived <= 1'b0;
    end
  end
endmodule

// File: rtl/bus_idle_inserter.sv
module bus_idle_inserter
  import bii_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [AREA_W-1:0] req_area,
  input  logic             req_write,
  output logic             bus_start,
  output logic             idle_active
);
  logic [NUM_AREAS-1:0][CODE_W-1:0] area_code;
  logic [NUM_AREAS-1:0]             area_has;
  hist_t prev;
  cnt_t  need;
  logic  fire;

  bii_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .area_code(area_code), .area_has(area_has)
  );

  bii_gap_calc u_calc (
    .area_code(area_code), .area_has(area_has), .prev(prev),
    .nxt_area(req_area), .nxt_write(req_write), .need(need)
  );

  bii_gap_timer u_timer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .need(need),
    .req_ready(req_ready), .idle_active(idle_active), .fire(fire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= '0;
    else if (fire) prev <= '{seen: 1'b1, area: req_area, write: req_write};
  end

  assign bus_start = fire;
endmodule

// File: rtl/bii_checker.sv
module bii_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_we,
  input logic [7:0] cfg_wdata,
  input logic [7:0] cfg_rdata,
  input logic       req_valid,
  input logic       req_ready,
  input logic       bus_start,
  input logic       idle_active
);
  logic [2:0] run;
  logic       started;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run     <= '0;
      started <= 1'b0;
    end else begin
      run <= idle_active ? run + 3'd1 : 3'd0;
      if (bus_start) started <= 1'b1;
    end
  end

  // R8
  ready_low_in_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_active |-> !req_ready);
  // R3
  max_three_idles_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_active |-> run < 3'd3);
  // R8
  start_after_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(idle_active) && req_valid) |-> bus_start);
  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[3:2] == 2'b00);
  // R2
  write_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_rdata == ($past(cfg_wdata) & 8'hF3));
  // R1
  first_unheld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!started && req_valid) |-> req_ready);
endmodule

bind bus_idle_inserter bii_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_ready(req_ready),
  .bus_start(bus_start), .idle_active(idle_active)
);

// File: tb/bus_idle_inserter_test.sv
module bus_idle_inserter_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [2:0] req_area = '0;
  logic       req_write = 1'b0;
  logic       bus_start;
  logic       idle_active;

  int checks = 0;
  int errors = 0;

  logic [7:0] m_cfg = 8'hF3;
  bit         m_have = 0;
  int         m_area = 0;
  bit         m_wr = 0;

  always #10 clk = ~clk;

  bus_idle_inserter uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_area(req_area), .req_write(req_write), .bus_start(bus_start),
    .idle_active(idle_active)
  );

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int field_idles(int a);
    int code;
    if (a == 0) code = m_cfg[1:0];
    else if (a == 2) code = m_cfg[5:4];
    else if (a == 3) code = m_cfg[7:6];
    else return 0;
    return (code < 2) ? 1 : code;
  endfunction

  function automatic int expect_idles(int a, bit w);
    if (!m_have) return 0;
    if (m_area != a) return field_idles(m_area);
    if (!m_wr && w) return field_idles(a);
    return 0;
  endfunction

  function automatic string classify(int a, bit w);
    if (!m_have) return "R1";
    if (m_area != a) return (m_area == 0 || m_area == 2 || m_area == 3) ? "R4" : "R7";
    if (!m_wr && w) return "R5";
    return "R6";
  endfunction

  task automatic cfg_write(logic [7:0] v);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    m_cfg = v & 8'hF3;
  endtask

  task automatic send(int a, bit w, bit mid_wr, logic [7:0] mv, string tag);
    int exp;
    int n;
    string req;
    exp = expect_idles(a, w);
    req = (tag == "") ? classify(a, w) : tag;
    n = 0;
    @(negedge clk);
    req_valid = 1'b1;
    req_area = 3'(a);
    req_write = w;
    #1;
    while (!req_ready && n < 8) begin
      check(idle_active == 1'b1, "R8", int'(idle_active), 1);
      @(negedge clk);
      if (mid_wr && n == 0) begin
        cfg_we = 1'b1;
        cfg_wdata = mv;
      end else cfg_we = 1'b0;
      #1;
      n++;
    end
    check(n == exp, req, n, exp);
    check(bus_start == 1'b1 && idle_active == 1'b0, "R8",
          int'({bus_start, idle_active}), 2);
    @(posedge clk);
    m_have = 1;
    m_area = a;
    m_wr = w;
    if (mid_wr) m_cfg = mv & 8'hF3;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check(cfg_rdata == 8'hF3, "R1", int'(cfg_rdata), 'hF3);
    check(idle_active == 1'b0, "R1", int'(idle_active), 0);
    send(3, 1'b1, 1'b0, 8'h00, "R1");

    // R2 every register value, reserved bits masked
    for (int v = 0; v < 256; v++) begin
      cfg_write(8'(v));
      #1;
      check(cfg_rdata == (8'(v) & 8'hF3), "R2", int'(cfg_rdata), v & 'hF3);
    end

    // R3..R7 every access pair under four field settings
    for (int k = 0; k < 4; k++) begin
      cfg_write({2'((k + 2) % 4), 2'((k + 1) % 4), 2'b00, 2'(k)});
      for (int pa = 0; pa < 8; pa++)
        for (int pw = 0; pw < 2; pw++)
          for (int na = 0; na < 8; na++)
            for (int nw = 0; nw < 2; nw++) begin
              send(pa, 1'(pw), 1'b0, 8'h00, "");
              send(na, 1'(nw), 1'b0, 8'h00, "");
            end
    end

    // R9 write during a countdown
    cfg_write(8'hF3);
    send(3, 1'b0, 1'b0, 8'h00, "");
    send(0, 1'b0, 1'b1, 8'h00, "R9");
    send(3, 1'b0, 1'b0, 8'h00, "R9");

    @(negedge clk);
    req_valid = 1'b0;
    repeat (2) @(negedge clk);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule